// File: doc/BRIEF.md
# Timer Channel Clock Gating Control

This block decides, for one timer/counter channel, whether each pulse of the already-selected counting clock reaches the counter. It keeps two independent held states. The enabled state is set and cleared by explicit software commands. The running state is set by triggers and cleared by stop events. A counting pulse (`tick`) advances the counter only while both states are 1. The enabled state is visible on a status output.

The channel works in one of two modes. In capture mode, a load of the B capture register can be chosen to stop the clock, to disable it, or both. In waveform mode, a match against the C compare value takes that role. Software picks these choices with configuration bits.

A plain up-counter with a C compare is included, so that compare events arise inside the block and their effect on the gate can be observed. The mode also fixes the direction of the channel's two I/O lines, which is reported on two output-enable pins.

Top module: `tcg_channel`

## Requirements
- R1: A cycle with `cmd_enable` high, and no disable source active, sets the enabled state from the next cycle. `clk_on` is 1 exactly while the enabled state is 1.
- R2: `cmd_disable` clears both the enabled and the running state at the next edge. When both commands arrive in the same cycle, the disable wins.
- R3: With `cfg_wave`=0, a `bload_evt` pulse does two things. It clears the running state when `cfg_bload_stop`=1, and the enabled state stays 1. It clears the enabled state when `cfg_bload_off`=1. With `cfg_wave`=1, `bload_evt` has no effect on either state.
- R4: With `cfg_wave`=1, a compare event does two things. It clears the running state when `cfg_cmatch_stop`=1. It clears the enabled state when `cfg_cmatch_off`=1. With `cfg_wave`=0, compare events have no effect on either state.
- R5: Any of `trig_sw`, `trig_sync` or `trig_ext` sets the running state at the next edge, but only if the enabled state is already 1 in that cycle. A trigger in the same cycle as `cmd_enable` on a disabled channel is ignored. `cmd_enable` alone never starts the clock.
- R6: When a trigger and an active stop event fall in the same cycle, the stop wins and the running state ends up 0.
- R7: `count_en` = `tick` AND enabled AND running. At each edge where `count_en` is 1, `count_val` advances by one, modulo 2^CNT_W. Otherwise `count_val` holds.
- R8: A compare event (`cmp_match`=1) is a cycle with `count_en`=1 and `count_val` equal to `cmp_c_val`. That same edge still advances the counter, so a compare-stop leaves `count_val` at C+1.
- R9: `line_a_oe` = `cfg_wave`. `line_b_oe` = `cfg_wave` AND NOT `cfg_b_is_trigger`. A value of 0 means the line is an input.
- R10: Synchronous `rst` clears the enabled state, the running state and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wave | input | 1 | 0 = capture mode, 1 = waveform mode |
| cfg_bload_stop | input | 1 | B load stops the clock (capture mode) |
| cfg_bload_off | input | 1 | B load disables the clock (capture mode) |
| cfg_cmatch_stop | input | 1 | C compare stops the clock (waveform mode) |
| cfg_cmatch_off | input | 1 | C compare disables the clock (waveform mode) |
| cfg_b_is_trigger | input | 1 | Line B is used as external trigger input |
| cmd_enable | input | 1 | Software enable command pulse |
| cmd_disable | input | 1 | Software disable command pulse |
| trig_sw | input | 1 | Software trigger pulse |
| trig_sync | input | 1 | Synchronous trigger pulse |
| trig_ext | input | 1 | External trigger pulse |
| bload_evt | input | 1 | B capture register load event pulse |
| tick | input | 1 | Selected counting clock pulse |
| cmp_c_val | input | CNT_W | C compare value |
| count_en | output | 1 | Gated count enable |
| count_val | output | CNT_W | Counter value |
| cmp_match | output | 1 | Compare event |
| clk_on | output | 1 | Enabled-state status |
| line_a_oe | output | 1 | Line A output enable |
| line_b_oe | output | 1 | Line B output enable |

## Verification
Two pairs of functions can collide in one cycle. The first pair is enable and disable, which the bench raises together while the channel runs. The second pair is a trigger and a stop, which the bench raises as a software trigger alongside a B-load stop while the tick is held low. In each case the bench then lets the tick run and judges the outcome at the ports. A frozen `count_val` and the value of `clk_on` show which side won. The bench also issues a trigger together with an enable on a disabled channel, and it confirms that no counting follows.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_WAVE    = 1'b1
    } tcg_mode_e;

    typedef struct packed {
        tcg_mode_e mode;
        logic      bload_stop;
        logic      bload_off;
        logic      cmatch_stop;
        logic      cmatch_off;
        logic      b_is_trigger;
    } tcg_cfg_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic off;
    } tcg_evt_t;

    // Mode-dependent choice of stop and disable sources.
    function automatic tcg_evt_t pick_events(
        input tcg_cfg_t cfg,
        input logic     bload,
        input logic     cmatch,
        input logic     sw_off,
        input logic     any_trig
    );
        tcg_evt_t e;
        if (cfg.mode == MODE_WAVE) begin
            e.stop = cmatch & cfg.cmatch_stop;
            e.off  = sw_off | (cmatch & cfg.cmatch_off);
        end else begin
            e.stop = bload & cfg.bload_stop;
            e.off  = sw_off | (bload & cfg.bload_off);
        end
        e.start = any_trig;
        return e;
    endfunction

endpackage

// File: rtl/tcg_event_sel.sv
module tcg_event_sel
    import tcg_pkg::*;
(
    input  tcg_cfg_t cfg,
    input  logic     cmd_disable,
    input  logic     trig_sw,
    input  logic     trig_sync,
    input  logic     trig_ext,
    input  logic     bload_evt,
    input  logic     cmp_hit,
    output tcg_evt_t evt
);
    logic any_trig;

    assign any_trig = trig_sw | trig_sync | trig_ext;

    always_comb begin
        evt = pick_events(cfg, bload_evt, cmp_hit, cmd_disable, any_trig);
    end
endmodule

// File: rtl/tcg_gate.sv
module tcg_gate
    import tcg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_enable,
    input  tcg_evt_t evt,
    input  logic     tick,
    output logic     en_q,
    output logic     run_q,
    output logic     gated
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            run_q <= 1'b0;
        end else if (evt.off) begin
            en_q  <= 1'b0;
            run_q <= 1'b0;
        end else begin
            if (cmd_enable) en_q <= 1'b1;
            if (en_q) begin
                if (evt.stop)       run_q <= 1'b0;
                else if (evt.start) run_q <= 1'b1;
            end
        end
    end

    assign gated = tick & en_q & run_q;
endmodule

// File: rtl/tcg_counter.sv
module tcg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic [CNT_W-1:0] c_val,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (inc) cnt <= cnt + ONE;
    end

    assign hit = inc & (cnt == c_val);
endmodule

// File: rtl/tcg_channel.sv
module tcg_channel
    import tcg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wave,
    input  logic             cfg_bload_stop,
    input  logic             cfg_bload_off,
    input  logic             cfg_cmatch_stop,
    input  logic             cfg_cmatch_off,
    input  logic             cfg_b_is_trigger,
    input  logic             cmd_enable,
    input  logic             cmd_disable,
    input  logic             trig_sw,
    input  logic             trig_sync,
    input  logic             trig_ext,
    input  logic             bload_evt,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_c_val,
    output logic             count_en,
    output logic [CNT_W-1:0] count_val,
    output logic             cmp_match,
    output logic             clk_on,
    output logic             line_a_oe,
    output logic             line_b_oe
);
    tcg_cfg_t cfg;
    tcg_evt_t evt;
    logic     en_q;
    logic     run_q;

    always_comb begin
        cfg.mode         = cfg_wave ? MODE_WAVE : MODE_CAPTURE;
        cfg.bload_stop   = cfg_bload_stop;
        cfg.bload_off    = cfg_bload_off;
        cfg.cmatch_stop  = cfg_cmatch_stop;
        cfg.cmatch_off   = cfg_cmatch_off;
        cfg.b_is_trigger = cfg_b_is_trigger;
    end

    tcg_event_sel u_sel (
        .cfg         (cfg),
        .cmd_disable (cmd_disable),
        .trig_sw     (trig_sw),
        .trig_sync   (trig_sync),
        .trig_ext    (trig_ext),
        .bload_evt   (bload_evt),
        .cmp_hit     (cmp_match),
        .evt         (evt)
    );

    tcg_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .cmd_enable (cmd_enable),
        .evt        (evt),
        .tick       (tick),
        .en_q       (en_q),
        .run_q      (run_q),
        .gated      (count_en)
    );

    tcg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (count_en),
        .c_val (cmp_c_val),
        .cnt   (count_val),
        .hit   (cmp_match)
    );

    assign clk_on    = en_q;
    assign line_a_oe = (cfg.mode == MODE_WAVE);
    assign line_b_oe = (cfg.mode == MODE_WAVE) & ~cfg.b_is_trigger;
endmodule

// File: rtl/tcg_channel_chk.sv
module tcg_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wave,
    input logic             cfg_cmatch_stop,
    input logic             cfg_b_is_trigger,
    input logic             cmd_enable,
    input logic             cmd_disable,
    input logic             bload_evt,
    input logic             count_en,
    input logic [CNT_W-1:0] count_val,
    input logic             cmp_match,
    input logic             clk_on,
    input logic             line_a_oe,
    input logic             line_b_oe
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
        cmd_disable |=> !clk_on); // R2

    AST_STOPPED_AFTER_OFF: assert property (@(posedge clk) disable iff (rst)
        cmd_disable |=> !count_en); // R2

    AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (rst)
        (cmd_enable && !cmd_disable && !bload_evt && !cmp_match) |=> clk_on); // R1

    AST_OFF_STAYS_OFF: assert property (@(posedge clk) disable iff (rst)
        (!clk_on && !cmd_enable) |=> !clk_on); // R5

    AST_COUNT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        count_en |-> clk_on); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        count_en |=> (count_val == $past(count_val) + ONE)); // R7

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> $stable(count_val)); // R7

    AST_MATCH_IS_TICK: assert property (@(posedge clk) disable iff (rst)
        cmp_match |-> count_en); // R8

    AST_CMATCH_STOPS: assert property (@(posedge clk) disable iff (rst)
        (cmp_match && cfg_wave && cfg_cmatch_stop) |=> !count_en); // R4

    AST_LINE_DIR: assert property (@(posedge clk) disable iff (rst)
        line_b_oe |-> (line_a_oe && !cfg_b_is_trigger)); // R9
endmodule

bind tcg_channel tcg_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tcg_channel_bench.sv
module tcg_channel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wave = 0, cfg_bload_stop = 0, cfg_bload_off = 0;
    logic cfg_cmatch_stop = 0, cfg_cmatch_off = 0, cfg_b_is_trigger = 0;
    logic cmd_enable = 0, cmd_disable = 0;
    logic trig_sw = 0, trig_sync = 0, trig_ext = 0, bload_evt = 0, tick = 0;
    logic [W-1:0] cmp_c_val = '1;
    logic count_en, cmp_match, clk_on, line_a_oe, line_b_oe;
    logic [W-1:0] count_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcg_channel #(.CNT_W(W)) u_tcg_channel (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        cfg_wave = 0; cfg_bload_stop = 0; cfg_bload_off = 0;
        cfg_cmatch_stop = 0; cfg_cmatch_off = 0; cfg_b_is_trigger = 0;
        cmd_enable = 0; cmd_disable = 0; trig_sw = 0; trig_sync = 0;
        trig_ext = 0; bload_evt = 0; tick = 0; cmp_c_val = '1;
    endtask

    task automatic do_reset();
        clear_all();
        rst = 1; cyc(2); rst = 0;
    endtask

    task automatic enable_and_start();
        cmd_enable = 1; cyc(); cmd_enable = 0;
        trig_sw = 1; cyc(); trig_sw = 0;
    endtask

    task automatic wait_count(input int v);
        for (int i = 0; i < 300 && count_val != W'(v); i++) cyc();
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R10 clk_on after reset", clk_on, 0);
        chk("R10 count after reset", count_val, 0);
        tick = 1; cyc();
        chk("R10 no count after reset", count_val, 0);
        tick = 0;
    endtask

    task automatic t_enable_count();
        do_reset();
        tick = 1;
        cmd_enable = 1; cyc(); cmd_enable = 0;
        chk("R1 enable sets status", clk_on, 1);
        chk("R5 enable alone does not start", count_val, 0);
        tick = 0; trig_sw = 1; cyc(); trig_sw = 0;
        chk("R7 count_en needs tick", count_en, 0);
        tick = 1; #1;
        chk("R7 count_en with tick", count_en, 1);
        cyc(3);
        chk("R7 three ticks", count_val, 3);
        tick = 0; cyc(2);
        chk("R7 hold without tick", count_val, 3);
    endtask

    task automatic t_enable_disable_same();
        cmd_enable = 1; cmd_disable = 1; cyc();
        cmd_enable = 0; cmd_disable = 0;
        chk("R2 disable wins over enable", clk_on, 0);
        cmd_enable = 1; cyc(); cmd_enable = 0;
        tick = 1; cyc(2);
        chk("R2 disable also cleared running", count_val, 3);
        tick = 0;
    endtask

    task automatic t_trig_when_off();
        do_reset();
        trig_sync = 1; cyc(); trig_sync = 0;
        chk("R5 trigger leaves disabled", clk_on, 0);
        cmd_enable = 1; trig_ext = 1; cyc(); cmd_enable = 0; trig_ext = 0;
        tick = 1; cyc();
        chk("R5 trigger with enable ignored", count_val, 0);
        trig_ext = 1; cyc(); trig_ext = 0;
        cyc();
        chk("R5 external trigger starts", count_val, 1);
        tick = 0;
    endtask

    task automatic t_capture_bload();
        int c0;
        do_reset();
        cfg_bload_stop = 1;
        enable_and_start();
        tick = 1; cyc(2);
        c0 = count_val;
        bload_evt = 1; cyc(); bload_evt = 0;
        chk("R3 bload stop edge still counts", count_val, c0 + 1);
        cyc(2);
        chk("R3 bload stop holds count", count_val, c0 + 1);
        chk("R3 bload stop keeps enabled", clk_on, 1);
        cfg_bload_stop = 0; cfg_bload_off = 1;
        trig_sw = 1; cyc(); trig_sw = 0;
        bload_evt = 1; cyc(); bload_evt = 0;
        chk("R3 bload disable clears enabled", clk_on, 0);
        cmd_enable = 1; cyc(); cmd_enable = 0;
        trig_sw = 1; cyc(); trig_sw = 0;
        cfg_wave = 1; cfg_bload_stop = 1;
        c0 = count_val;
        bload_evt = 1; cyc(); bload_evt = 0;
        cyc(2);
        chk("R3 bload ignored in waveform", count_val, c0 + 3);
        chk("R3 bload ignored in waveform status", clk_on, 1);
        tick = 0;
    endtask

    task automatic t_wave_cmatch();
        do_reset();
        cfg_wave = 1; cfg_cmatch_stop = 1; cmp_c_val = 5;
        enable_and_start();
        tick = 1;
        wait_count(5);
        #1;
        chk("R8 compare event at C", cmp_match, 1);
        cyc();
        chk("R8 compare edge advances to C+1", count_val, 6);
        cyc(2);
        chk("R4 compare stop holds count", count_val, 6);
        chk("R4 compare stop keeps enabled", clk_on, 1);
        cfg_cmatch_stop = 0; cfg_cmatch_off = 1; cmp_c_val = 8;
        trig_sw = 1; cyc(); trig_sw = 0;
        wait_count(8);
        cyc();
        chk("R4 compare disable clears enabled", clk_on, 0);
        chk("R4 compare disable count", count_val, 9);
        tick = 0;
        do_reset();
        cfg_cmatch_stop = 1; cfg_cmatch_off = 1; cmp_c_val = 3;
        enable_and_start();
        tick = 1;
        wait_count(3);
        cyc(2);
        chk("R4 compare ignored in capture", count_val, 5);
        chk("R4 compare ignored in capture status", clk_on, 1);
        tick = 0;
    endtask

    task automatic t_stop_vs_trig();
        int c0;
        do_reset();
        cfg_bload_stop = 1;
        enable_and_start();
        tick = 1; cyc(2); tick = 0;
        c0 = count_val;
        bload_evt = 1; trig_sw = 1; cyc(); bload_evt = 0; trig_sw = 0;
        tick = 1; cyc(2);
        chk("R6 stop beats trigger", count_val, c0);
        tick = 0;
    endtask

    task automatic t_lines();
        cfg_wave = 0; cfg_b_is_trigger = 0; #1;
        chk("R9 capture line A input", line_a_oe, 0);
        chk("R9 capture line B input", line_b_oe, 0);
        cfg_wave = 1; #1;
        chk("R9 wave line A output", line_a_oe, 1);
        chk("R9 wave line B output", line_b_oe, 1);
        cfg_b_is_trigger = 1; #1;
        chk("R9 wave line B trigger input", line_b_oe, 0);
        cyc();
    endtask

    task automatic t_reset_midrun();
        do_reset();
        enable_and_start();
        tick = 1; cyc(4);
        rst = 1; cyc(); rst = 0;
        chk("R10 reset clears enabled", clk_on, 0);
        chk("R10 reset clears counter", count_val, 0);
        cyc(2);
        chk("R10 reset clears running", count_val, 0);
        tick = 0;
    endtask

    initial begin
        cyc(2);
        t_reset_state();
        t_enable_count();
        t_enable_disable_same();
        t_trig_when_off();
        t_capture_bload();
        t_wave_cmatch();
        t_stop_vs_trig();
        t_lines();
        t_reset_midrun();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule